// File: doc/BRIEF.md
# Serial Audio Sample Transmitter

This block sends stereo two's complement audio samples over a three-wire serial audio link and acts as its master. It generates the bit clock from a system-clock enable, derives the frame (word-select) clock from the bit clock, and shifts sample bits out on a data line. Each frame has a left slot followed by a right slot. Each slot is 32 bit periods long, whatever the sample width.

At the start of each frame the block captures a left word, a right word, a framing selection (I2S, left-justified or right-justified) and a width selection (16, 20 or 24 bits). It holds all four for the whole frame. The framing and the width together set where the sample bits sit inside each slot. Every bit period that carries no sample bit is sent as zero. Samples are supplied on a `SAMPLE_W`-bit input. A narrower width sends only the upper bits of that word.

Top module: `audio_serial_tx`

## Requirements
- R1: `lrclk_o` changes only at slot boundaries. A frame lasts 64 bit periods and each slot lasts 32.
- R2: `bclk_o` inverts in every cycle in which `tick_en` is high and holds in every other cycle, so one bit period spans two ticks.
- R3: `sdata_o` and `lrclk_o` change only in the cycle in which `bclk_o` falls.
- R4: While reset is asserted, `bclk_o`, `lrclk_o` and `sdata_o` are low. The first falling edge of `bclk_o` after reset opens the left slot of the first frame.
- R5: Format code 00, and also code 11, selects I2S framing: `lrclk_o` is low in the left slot and high in the right slot, and the MSB occupies slot period 1. Slot periods are numbered 0 to 31, and period 0 starts at the falling edge that opens the slot.
- R6: Format code 10 selects left-justified framing: `lrclk_o` is high in the left slot, and the MSB occupies slot period 0.
- R7: Format code 01 selects right-justified framing: `lrclk_o` is high in the left slot, and the LSB occupies slot period 31.
- R8: Width code 00 means 24 bits, 01 means 20 bits, 10 means 16 bits and 11 means 24 bits. The transmitted sample is the top W bits of the input word, starting from bit 23 with the default `SAMPLE_W` of 24. It is sent MSB first with no change to its bits, so full-scale codes such as 0x7FFFFF and 0x800001 appear exactly as given.
- R9: Every slot period that does not carry a sample bit is driven as 0.
- R10: Both samples and both control fields are captured in the cycle of the falling edge that opens the left slot. A change to any of them later in the frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Half-bit-period enable; `bclk_o` inverts on each tick |
| fmt_sel | input | 2 | Framing code: 00 I2S, 01 right-justified, 10 left-justified, 11 I2S |
| width_sel | input | 2 | Width code: 00 24, 01 20, 10 16, 11 24 bits |
| left_in | input | SAMPLE_W | Left channel sample, two's complement |
| right_in | input | SAMPLE_W | Right channel sample, two's complement |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock / channel select |
| sdata_o | output | 1 | Serial data, updated on the falling edge of `bclk_o` |

## Verification
The slot-length assertion counts `bclk_o` falling edges between `lrclk_o` changes modulo 32. This allows a change of framing, which can merge two slots of equal `lrclk_o` level, while any other gap length still fails. The edge assertions assume that `tick_en` is held low during reset, and the stimulus keeps it low there. The stimulus changes the samples and the control fields only away from frame boundaries: either right after the last bit of a frame has been seen, or deep inside a frame. The mid-frame changes are what exercise the capture rule. The bench decodes each frame independently, by counting falling edges of `bclk_o` from reset.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

   typedef enum logic [1:0] {
      FMT_I2S     = 2'b00,
      FMT_RJ      = 2'b01,
      FMT_LJ      = 2'b10,
      FMT_I2S_ALT = 2'b11
   } fmt_e;

   // Width code to bit count; the unused code falls back to the widest.
   function automatic int unsigned width_of(input logic [1:0] code);
      case (code)
         2'b01:   return 20;
         2'b10:   return 16;
         default: return 24;
      endcase
   endfunction

   function automatic logic is_i2s(input fmt_e f);
      return (f == FMT_I2S) || (f == FMT_I2S_ALT);
   endfunction

endpackage

// File: rtl/audio_tx_timebase.sv
// Half-bit phase and frame bit position. The position resets to the last
// bit so that the first falling bit clock edge opens bit 0 of a frame.
module audio_tx_timebase #(
   parameter int unsigned SLOT_W = 32,
   localparam int unsigned POS_W = $clog2(SLOT_W) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   output logic             bclk,
   output logic             fall,
   output logic [POS_W-1:0] next_pos
);

   logic             half_q;
   logic [POS_W-1:0] pos_q;

   assign bclk     = half_q;
   assign fall     = tick_en & half_q;
   assign next_pos = pos_q + POS_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         half_q <= 1'b0;
         pos_q  <= '1;
      end else if (tick_en) begin
         half_q <= ~half_q;
         if (half_q) pos_q <= next_pos;
      end
   end

endmodule

// File: rtl/audio_tx_slot_map.sv
// Maps a frame bit position to the data bit and frame clock level for the
// selected framing and width.
module audio_tx_slot_map
   import audio_tx_pkg::*;
#(
   parameter int unsigned SLOT_W   = 32,
   parameter int unsigned SAMPLE_W = 24,
   localparam int unsigned OFF_W   = $clog2(SLOT_W),
   localparam int unsigned POS_W   = OFF_W + 1,
   localparam int unsigned CW      = OFF_W + 1
) (
   input  logic [POS_W-1:0]    pos,
   input  logic [1:0]          fmt,
   input  logic [1:0]          wcode,
   input  logic [SAMPLE_W-1:0] left,
   input  logic [SAMPLE_W-1:0] right,
   output logic                bit_o,
   output logic                lr_o
);

   fmt_e                f;
   logic                slot;
   logic [CW-1:0]       p;
   logic [CW-1:0]       wv;
   logic [CW-1:0]       first;
   logic [CW-1:0]       offs;
   logic                hit;
   logic [SAMPLE_W-1:0] word;
   logic [SAMPLE_W-1:0] shifted;

   always_comb begin
      f     = fmt_e'(fmt);
      slot  = pos[POS_W-1];
      p     = {1'b0, pos[OFF_W-1:0]};
      wv    = CW'(width_of(wcode));
      case (f)
         FMT_LJ:  first = '0;
         FMT_RJ:  first = CW'(SLOT_W) - wv;
         default: first = CW'(1);
      endcase
      word    = slot ? right : left;
      hit     = (p >= first) && (p < (first + wv));
      offs    = p - first;
      shifted = word << offs;
      bit_o   = hit & shifted[SAMPLE_W-1];
      lr_o    = is_i2s(f) ? slot : ~slot;
   end

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx #(
   parameter int unsigned SLOT_W   = 32,
   parameter int unsigned SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_en,
   input  logic [1:0]          fmt_sel,
   input  logic [1:0]          width_sel,
   input  logic [SAMPLE_W-1:0] left_in,
   input  logic [SAMPLE_W-1:0] right_in,
   output logic                bclk_o,
   output logic                lrclk_o,
   output logic                sdata_o
);

   localparam int unsigned POS_W = $clog2(SLOT_W) + 1;

   if ((1 << $clog2(SLOT_W)) != SLOT_W) begin : g_bad_slot
      $error("SLOT_W must be a power of two");
   end
   if (SAMPLE_W < 24 || SAMPLE_W >= SLOT_W) begin : g_bad_sample
      $error("SAMPLE_W must be at least 24 and below SLOT_W");
   end

   logic                fall;
   logic [POS_W-1:0]    next_pos;
   logic                frame_start;
   logic [1:0]          fmt_q, wid_q, fmt_cur, wid_cur;
   logic [SAMPLE_W-1:0] left_q, right_q, left_cur, right_cur;
   logic                map_bit, map_lr;
   logic                sdata_q, lr_q;

   audio_tx_timebase #(.SLOT_W(SLOT_W)) u_time (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .bclk     (bclk_o),
      .fall     (fall),
      .next_pos (next_pos)
   );

   assign frame_start = fall && (next_pos == '0);

   // At a frame start the fresh inputs feed bit 0 directly.
   assign fmt_cur   = frame_start ? fmt_sel   : fmt_q;
   assign wid_cur   = frame_start ? width_sel : wid_q;
   assign left_cur  = frame_start ? left_in   : left_q;
   assign right_cur = frame_start ? right_in  : right_q;

   audio_tx_slot_map #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W)) u_map (
      .pos   (next_pos),
      .fmt   (fmt_cur),
      .wcode (wid_cur),
      .left  (left_cur),
      .right (right_cur),
      .bit_o (map_bit),
      .lr_o  (map_lr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fmt_q   <= 2'b00;
         wid_q   <= 2'b00;
         left_q  <= '0;
         right_q <= '0;
         sdata_q <= 1'b0;
         lr_q    <= 1'b0;
      end else begin
         if (frame_start) begin
            fmt_q   <= fmt_sel;
            wid_q   <= width_sel;
            left_q  <= left_in;
            right_q <= right_in;
         end
         if (fall) begin
            sdata_q <= map_bit;
            lr_q    <= map_lr;
         end
      end
   end

   assign sdata_o = sdata_q;
   assign lrclk_o = lr_q;

endmodule

// File: rtl/audio_serial_tx_chk.sv
module audio_serial_tx_chk #(
   parameter int unsigned SLOT_W = 32,
   localparam int unsigned GW    = $clog2(SLOT_W)
) (
   input logic clk,
   input logic rst_n,
   input logic tick_en,
   input logic bclk_o,
   input logic lrclk_o,
   input logic sdata_o
);

   logic          bclk_q, lr_q, armed, rst_low_q;
   logic [GW-1:0] gap;

   always_ff @(posedge clk) begin
      rst_low_q <= !rst_n;
      if (!rst_n) begin
         bclk_q <= 1'b0;
         lr_q   <= 1'b0;
         armed  <= 1'b0;
         gap    <= '0;
      end else begin
         bclk_q <= bclk_o;
         lr_q   <= lrclk_o;
         if (bclk_q && !bclk_o) begin
            if (lrclk_o != lr_q) begin
               if (armed) begin
                  p_slot_len_r1: assert (gap == GW'(SLOT_W - 1))
                     else $error("frame clock changed off a slot boundary");
               end
               armed <= 1'b1;
               gap   <= '0;
            end else begin
               gap <= gap + GW'(1);
            end
         end
      end
   end

   // R4: outputs low while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n && rst_low_q) begin
         p_reset_low_r4: assert (!bclk_o && !lrclk_o && !sdata_o)
            else $error("outputs not low in reset");
      end
   end

   p_bclk_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> (bclk_o != $past(bclk_o)));

   p_bclk_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(bclk_o));

   p_data_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(bclk_o) |-> ($stable(sdata_o) && $stable(lrclk_o)));

endmodule

bind audio_serial_tx audio_serial_tx_chk #(.SLOT_W(SLOT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick_en (tick_en),
   .bclk_o  (bclk_o),
   .lrclk_o (lrclk_o),
   .sdata_o (sdata_o)
);

// File: tb/audio_serial_tx_tb.sv
`timescale 1ns/1ps
module audio_serial_tx_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        run_tick = 1'b0;
   logic [1:0]  fmt_sel = 2'b00;
   logic [1:0]  width_sel = 2'b00;
   logic [23:0] left_in = '0;
   logic [23:0] right_in = '0;
   logic        bclk_o, lrclk_o, sdata_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   audio_serial_tx u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .fmt_sel(fmt_sel), .width_sel(width_sel),
      .left_in(left_in), .right_in(right_in),
      .bclk_o(bclk_o), .lrclk_o(lrclk_o), .sdata_o(sdata_o)
   );

   always @(negedge clk) begin
      if (rst_n && run_tick) tick_en <= ~tick_en;
      else                   tick_en <= 1'b0;
   end

   // Receiver model: bit position from falling edges counted since reset.
   int          falls = 0;
   int          frames = 0;
   int          since_fall = 0;
   int          period_err = 0;
   int          edge_err = 0;
   logic        pb = 1'b0, pl = 1'b0, pd = 1'b0;
   logic [63:0] cap_d, cap_lr, done_d, done_lr;

   always @(negedge clk) begin
      if (rst_n) begin
         since_fall++;
         if (pb && !bclk_o) begin
            if (falls > 0 && since_fall != 4) period_err++;
            falls++;
            since_fall = 0;
         end else if (lrclk_o != pl || sdata_o != pd) begin
            edge_err++;
         end
         if (!pb && bclk_o && falls > 0) begin
            int p;
            p = (falls - 1) % 64;
            cap_d[p]  = sdata_o;
            cap_lr[p] = lrclk_o;
            if (p == 63) begin
               done_d  = cap_d;
               done_lr = cap_lr;
               frames++;
            end
         end
      end
      pb = bclk_o;
      pl = lrclk_o;
      pd = sdata_o;
   end

   function automatic void exp_frame(input logic [1:0] f, input logic [1:0] w,
                                     input logic [23:0] l, input logic [23:0] r,
                                     output logic [63:0] d, output logic [63:0] lr);
      int wd;
      int st;
      bit i2s;
      wd  = (w == 2'b01) ? 20 : (w == 2'b10) ? 16 : 24;
      i2s = (f == 2'b00) || (f == 2'b11);
      st  = i2s ? 1 : (f == 2'b10) ? 0 : 32 - wd;
      for (int s = 0; s < 2; s++) begin
         for (int k = 0; k < 32; k++) begin
            logic [23:0] wrd;
            wrd = (s == 1) ? r : l;
            lr[s*32+k] = i2s ? (s == 1) : (s == 0);
            d[s*32+k]  = (k >= st && k < st + wd) ? wrd[23-(k-st)] : 1'b0;
         end
      end
   endfunction

   task automatic check1(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_frame();
      int f0;
      f0 = frames;
      wait (frames != f0);
   endtask

   function automatic string fmt_tag(input logic [1:0] f);
      if (f == 2'b10) return "R6 R8 R9";
      if (f == 2'b01) return "R7 R8 R9";
      return "R5 R8 R9";
   endfunction

   task automatic check_frame(input logic [1:0] f, input logic [1:0] w,
                              input logic [23:0] l, input logic [23:0] r, input string note);
      logic [63:0] ed, el;
      exp_frame(f, w, l, r, ed, el);
      check1({fmt_tag(f), " data ", note}, done_d, ed);
      check1({"R1 lrclk ", fmt_tag(f), " ", note}, done_lr, el);
   endtask

   // {fmt, width, left, right}
   localparam logic [51:0] VEC [10] = '{
      {2'b00, 2'b00, 24'h7FFFFF, 24'h800001},
      {2'b10, 2'b00, 24'h123456, 24'hABCDEF},
      {2'b01, 2'b00, 24'hA5A5A5, 24'h5A5A5A},
      {2'b00, 2'b01, 24'h876543, 24'h0F0F0F},
      {2'b10, 2'b01, 24'hFEDCBA, 24'h135790},
      {2'b01, 2'b01, 24'hC3C3C3, 24'h3C3C3C},
      {2'b00, 2'b10, 24'h8000FF, 24'h7FFF00},
      {2'b10, 2'b10, 24'hFFFFFF, 24'h000001},
      {2'b01, 2'b10, 24'h96E1AB, 24'h69F0C3},
      {2'b11, 2'b11, 24'h800001, 24'h7FFFFF}
   };

   initial begin
      repeat (5) @(negedge clk);
      check1("R4 reset outputs", {61'd0, bclk_o, lrclk_o, sdata_o}, 64'd0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check1("R2 R4 idle without ticks", {61'd0, bclk_o, lrclk_o, sdata_o}, 64'd0);

      fmt_sel = VEC[0][51:50]; width_sel = VEC[0][49:48];
      left_in = VEC[0][47:24]; right_in = VEC[0][23:0];
      run_tick = 1'b1;
      wait_frame();
      check_frame(VEC[0][51:50], VEC[0][49:48], VEC[0][47:24], VEC[0][23:0], "R4 first frame");

      for (int i = 0; i < 10; i++) begin
         fmt_sel = VEC[i][51:50]; width_sel = VEC[i][49:48];
         left_in = VEC[i][47:24]; right_in = VEC[i][23:0];
         wait_frame();
         wait_frame();
         check_frame(VEC[i][51:50], VEC[i][49:48], VEC[i][47:24], VEC[i][23:0], "vector");
      end

      // R10: settings and samples change in mid-frame, current frame unaffected
      fmt_sel = 2'b10; width_sel = 2'b00; left_in = 24'h3C5A96; right_in = 24'hC3A569;
      wait_frame();
      repeat (100) @(negedge clk);
      fmt_sel = 2'b01; width_sel = 2'b10; left_in = 24'hF0F0F0; right_in = 24'h0F0F0F;
      wait_frame();
      check_frame(2'b10, 2'b00, 24'h3C5A96, 24'hC3A569, "R10 mid-frame change ignored");
      wait_frame();
      check_frame(2'b01, 2'b10, 24'hF0F0F0, 24'h0F0F0F, "R10 next frame takes change");

      check1("R3 changes only on falling bclk", 64'(edge_err), 64'd0);
      check1("R2 bit period two ticks", 64'(period_err), 64'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule